// File: doc/BRIEF.md
# Successive-Approximation Converter Serial Port Emulator

This block stands in for the digital side of a successive-approximation converter so that a host-side serial controller can be exercised against it. A testbench or system model drives a parallel level word. A rising edge on the convert input then captures that word and starts a conversion window of fixed length. When the window ends, the captured code is shifted out most significant bit first on the serial clock. The serial data output also acts as a busy indicator. Its polarity and enable depend on how the part is wired.

Three wirings are supported and are picked by a strap input. In the conventional wiring, the serial data input acts as an active-low select. In the single-device wiring, the convert line itself gates the output. In the chain wiring, the serial data input carries the next device's stream, which is forwarded after the local result. The conversion window is counted in clock cycles from nanosecond parameters, with a shorter window in fast mode. Fast mode cannot be used with the chain wiring and is flagged as an error there. All inputs are taken as synchronous to `clk`, and all outputs are registered.

Top module: `sar_port_emu`

## Requirements
- R1: A rising edge of `cnv` while no conversion is running captures `sample_level` and starts a conversion, and `busy` is 1 from the following cycle.
- R2: `busy` stays high for ceil(T_CONV_NS/CLK_PERIOD_NS) cycles, which is 50 at defaults. If `turbo` is 1 at the start edge and the wiring is not chain, it stays high for ceil(T_FAST_NS/CLK_PERIOD_NS) cycles, which is 40.
- R3: A rising edge of `cnv` during a conversion is ignored and does not restart or lengthen it.
- R4: With DIFF_OUT=1 (the default, 18 bits), the shifted code is `sample_level` with its top bit inverted, which gives two's complement from offset binary. With DIFF_OUT=0 it is `sample_level` unchanged.
- R5: `wiring_mode` is encoded as 0 conventional, 1 single-device, 2 chain, and 3 behaves as conventional. In conventional and single-device wiring, `sdo` is 1 while converting and 0 once done. In chain wiring, it is 0 while converting and 1 once done.
- R6: After completion, the k-th falling edge of `sclk` drives code bit RES_BITS-k on `sdo`, so the output is MSB first. `sdo` does not change between falling edges, and falling edges during a conversion have no effect.
- R7: After RES_BITS bits, chain wiring outputs, at falling edge j+RES_BITS, the `sdi` value sampled at the `sclk` rising edge before falling edge j. The other wirings output 0.
- R8: `sdo_oe` is registered. In single-device wiring it is `!cnv`. In chain wiring it is 1 unless `cnv` is high with no conversion pending or done. In conventional wiring it is `!sdi` under the same idle condition.
- R9: `err_turbo_chain` is 1 in the cycle after `turbo` is high while the wiring is chain, and 0 otherwise. In that case the conversion uses the normal window.
- R10: During reset, `busy`, `sdo`, `sdo_oe` and `err_turbo_chain` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv | input | 1 | Convert start, rising-edge triggered |
| sdi | input | 1 | Select (conventional) or downstream data (chain) |
| sclk | input | 1 | Serial clock from the host |
| turbo | input | 1 | Fast conversion request |
| wiring_mode | input | 2 | Wiring strap: 0 conventional, 1 single, 2 chain |
| sample_level | input | RES_BITS | Level word captured at conversion start |
| sdo | output | 1 | Serial data and busy indicator |
| sdo_oe | output | 1 | Drive enable for `sdo` (0 means high impedance) |
| busy | output | 1 | Conversion in progress |
| err_turbo_chain | output | 1 | Fast mode requested in chain wiring |

## Verification
On every cycle, the assertions check that a running conversion is never shortened or reloaded by a new `cnv` edge. They also check that `busy` only rises after a convert edge, that `sdo` holds between serial clock falling edges while data is ready, that the output is disabled while idle with `cnv` high, and that the error flag stays clear without `turbo`. The bench scenarios are needed for the rest. These cover the exact window length in each mode, the code transform, the bit order, the busy polarity per wiring, and the chain forwarding delay of one full word.

// File: rtl/sar_emu_pkg.sv
package sar_emu_pkg;
  typedef enum logic [1:0] {
    WIRE_CONV   = 2'd0,
    WIRE_SINGLE = 2'd1,
    WIRE_CHAIN  = 2'd2,
    WIRE_RSVD   = 2'd3
  } wire_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_READY = 2'd2
  } conv_st_e;

  function automatic int ns_to_cycles(input int ns, input int period);
    return (ns + period - 1) / period;
  endfunction
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  generate
    if (RISING) begin : g_rise
      assign edge_o = sig_i & ~prev_q;
    end else begin : g_fall
      assign edge_o = ~sig_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_emu_pkg::*;
#(
  parameter int NORM_CYC = 50,
  parameter int FAST_CYC = 40
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start_req,
  input  logic     fast_i,
  output conv_st_e state_o,
  output logic     start_o,
  output logic     done_o,
  output logic     busy_o
);
  localparam int MAX_CYC = (NORM_CYC > FAST_CYC) ? NORM_CYC : FAST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  conv_st_e         st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign start_o = start_req && (st_q != ST_CONV);
  assign done_o  = (st_q == ST_CONV) && (cnt_q == '0);
  assign state_o = st_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_o) begin
      st_q   <= ST_CONV;
      cnt_q  <= fast_i ? CNT_W'(FAST_CYC - 1) : CNT_W'(NORM_CYC - 1);
      busy_q <= 1'b1;
    end else if (st_q == ST_CONV) begin
      if (cnt_q == '0) begin
        st_q   <= ST_READY;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R2: busy holds until the window count reaches its end
  p_busy_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done_o) |=> busy_q);

  // R1: busy only rises after a convert edge
  p_busy_src_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_req));

  // R3: a running window is never reloaded
  p_no_reload_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV && cnt_q != '0) |=> (st_q == ST_CONV && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sar_out_shift.sv
module sar_out_shift #(
  parameter int RES_BITS = 18,
  parameter bit DIFF_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                conv_i,
  input  logic                done_i,
  input  logic                ready_i,
  input  logic                sclk_rise_i,
  input  logic                sclk_fall_i,
  input  logic                sdi_i,
  input  logic                chain_i,
  input  logic                done_lvl_i,
  input  logic [RES_BITS-1:0] level_i,
  output logic                sdo_o
);
  logic [RES_BITS-1:0] code;
  logic [RES_BITS-1:0] shreg_q;
  logic                sdo_q;
  logic                cap_q;

  generate
    if (DIFF_OUT) begin : g_twos
      assign code = {~level_i[RES_BITS-1], level_i[RES_BITS-2:0]};
    end else begin : g_plain
      assign code = level_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      if (sclk_rise_i) cap_q <= sdi_i;
      if (start_i) begin
        shreg_q <= code;
        sdo_q   <= ~done_lvl_i;
      end else if (done_i) begin
        sdo_q <= done_lvl_i;
      end else if (conv_i) begin
        sdo_q <= ~done_lvl_i;
      end else if (ready_i && sclk_fall_i) begin
        sdo_q   <= shreg_q[RES_BITS-1];
        shreg_q <= {shreg_q[RES_BITS-2:0], chain_i ? cap_q : 1'b0};
      end
    end
  end

  assign sdo_o = sdo_q;

  // R6: output holds between serial clock falling edges once data is ready
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ready_i && !sclk_fall_i && !start_i) |=> $stable(sdo_q));
endmodule

// File: rtl/sar_port_emu.sv
module sar_port_emu
  import sar_emu_pkg::*;
#(
  parameter int RES_BITS      = 18,
  parameter bit DIFF_OUT      = 1'b1,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_CONV_NS     = 500,
  parameter int T_FAST_NS     = 400
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnv,
  input  logic                sdi,
  input  logic                sclk,
  input  logic                turbo,
  input  logic [1:0]          wiring_mode,
  input  logic [RES_BITS-1:0] sample_level,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                busy,
  output logic                err_turbo_chain
);
  localparam int NORM_CYC = ns_to_cycles(T_CONV_NS, CLK_PERIOD_NS);
  localparam int FAST_CYC = ns_to_cycles(T_FAST_NS, CLK_PERIOD_NS);

  wire_mode_e mode;
  logic       chain;
  logic       cnv_rise, sclk_rise, sclk_fall;
  conv_st_e   st;
  logic       start, done, idle;
  logic       oe_n, oe_q, err_q;

  assign mode  = wire_mode_e'(wiring_mode);
  assign chain = (mode == WIRE_CHAIN);
  assign idle  = (st == ST_IDLE);

  sar_edge_det #(.RISING(1'b1)) u_cnv_rise  (.clk(clk), .rst(rst), .sig_i(cnv),  .edge_o(cnv_rise));
  sar_edge_det #(.RISING(1'b1)) u_sclk_rise (.clk(clk), .rst(rst), .sig_i(sclk), .edge_o(sclk_rise));
  sar_edge_det #(.RISING(1'b0)) u_sclk_fall (.clk(clk), .rst(rst), .sig_i(sclk), .edge_o(sclk_fall));

  sar_conv_ctrl #(.NORM_CYC(NORM_CYC), .FAST_CYC(FAST_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .start_req(cnv_rise), .fast_i(turbo & ~chain),
    .state_o(st), .start_o(start), .done_o(done), .busy_o(busy)
  );

  sar_out_shift #(.RES_BITS(RES_BITS), .DIFF_OUT(DIFF_OUT)) u_shift (
    .clk(clk), .rst(rst), .start_i(start), .conv_i(st == ST_CONV), .done_i(done),
    .ready_i(st == ST_READY), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .sdi_i(sdi), .chain_i(chain), .done_lvl_i(chain), .level_i(sample_level),
    .sdo_o(sdo)
  );

  always_comb begin
    case (mode)
      WIRE_SINGLE: oe_n = ~cnv;
      WIRE_CHAIN:  oe_n = ~(cnv & idle);
      default:     oe_n = ~sdi & ~(cnv & idle);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      oe_q  <= oe_n;
      err_q <= turbo & chain;
    end
  end

  assign sdo_oe          = oe_q;
  assign err_turbo_chain = err_q;

  // R8: no drive while idle with convert held high
  p_oe_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (idle && cnv) |=> !sdo_oe);

  // R9: error flag needs the fast request
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !turbo |=> !err_turbo_chain);
endmodule

// File: tb/sar_port_emu_tb.sv
module sar_port_emu_tb_top;
  localparam int N    = 18;
  localparam int NORM = 50;
  localparam int FAST = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnv = 1'b0, sdi = 1'b0, sclk = 1'b0, turbo = 1'b0;
  logic [1:0] wiring_mode = 2'd0;
  logic [N-1:0] sample_level = '0;
  logic sdo, sdo_oe, busy, err_turbo_chain;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_port_emu dut_i (
    .clk(clk), .rst(rst), .cnv(cnv), .sdi(sdi), .sclk(sclk), .turbo(turbo),
    .wiring_mode(wiring_mode), .sample_level(sample_level),
    .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .err_turbo_chain(err_turbo_chain)
  );

  function automatic logic [N-1:0] exp_code(input logic [N-1:0] lvl);
    return lvl ^ (N'(1) << (N - 1));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_conv(input bit drop, input bit glitch, input bit tick,
                          output int len, output logic f_oe, output logic m_sdo,
                          output logic m_oe);
    @(negedge clk) cnv = 1'b0;
    @(negedge clk) cnv = 1'b1;
    @(negedge clk);
    f_oe = sdo_oe; len = 0; m_sdo = 1'bx; m_oe = 1'bx;
    while (busy === 1'b1 && len < 1000) begin
      len++;
      if (drop && len == 1) cnv = 1'b0;
      if (glitch && (len == 5 || len == 7)) cnv = ~cnv;
      if (tick && len == 10) sclk = 1'b1;
      if (tick && len == 11) sclk = 1'b0;
      if (len == 20) begin m_sdo = sdo; m_oe = sdo_oe; end
      @(negedge clk);
    end
  endtask

  task automatic read_bit(input logic d, output logic b);
    @(negedge clk) begin sdi = d; sclk = 1'b1; end
    @(negedge clk) sclk = 1'b0;
    @(negedge clk) b = sdo;
  endtask

  task automatic read_word(input string req, input logic [N-1:0] code, input logic idle_sdi);
    logic b;
    for (int k = 1; k <= N; k++) begin
      read_bit(idle_sdi, b);
      chk(req, b, code[N-k]);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int len;
    logic f_oe, m_sdo, m_oe, b;
    logic [N-1:0] lvl;
    logic [5:0] pat;
    void'($urandom(32'd7391));

    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 busy", busy, 0);
    chk("R10 sdo", sdo, 0);
    chk("R10 oe", sdo_oe, 0);
    chk("R10 err", err_turbo_chain, 0);
    rst = 1'b0;

    // Conventional, select high: normal window, output disabled, midscale code
    wiring_mode = 2'd0; sdi = 1'b1; sample_level = 18'h20000;
    run_conv(0, 0, 0, len, f_oe, m_sdo, m_oe);
    chk("R2 normal window", len, NORM);
    chk("R8 select high disables", m_oe, 0);
    @(negedge clk) sdi = 1'b0;
    @(negedge clk);
    chk("R8 select low enables", sdo_oe, 1);
    chk("R5 conventional done level", sdo, 0);
    read_word("R4 R6 midscale code", exp_code(18'h20000), 1'b0);
    read_bit(1'b0, b); chk("R7 conventional trailing zero", b, 0);
    read_bit(1'b0, b); chk("R7 conventional trailing zero", b, 0);

    // Conventional fast with ignored re-edge and an early serial clock
    turbo = 1'b1; sample_level = 18'h3FFFF;
    run_conv(0, 1, 1, len, f_oe, m_sdo, m_oe);
    chk("R2 R3 fast window with re-edge", len, FAST);
    chk("R5 conventional busy level", m_sdo, 1);
    chk("R8 conventional enabled", m_oe, 1);
    chk("R5 conventional done level", sdo, 0);
    read_word("R6 early falls ignored, MSB first", exp_code(18'h3FFFF), 1'b0);
    turbo = 1'b0;

    // Single-device
    wiring_mode = 2'd1; sdi = 1'b1; sample_level = 18'h00000;
    run_conv(1, 1, 0, len, f_oe, m_sdo, m_oe);
    chk("R3 single re-edge ignored", len, NORM);
    chk("R8 single oe follows cnv high", f_oe, 0);
    chk("R8 single oe follows cnv low", m_oe, 1);
    chk("R5 single busy level", m_sdo, 1);
    chk("R5 single done level", sdo, 0);
    read_word("R4 R6 zero level code", exp_code(18'h00000), 1'b1);

    // Chain with fast request: error flag, normal window, forwarding
    wiring_mode = 2'd2; turbo = 1'b1; sample_level = 18'h1A5C3;
    @(negedge clk);
    chk("R9 error flag set", err_turbo_chain, 1);
    run_conv(0, 0, 0, len, f_oe, m_sdo, m_oe);
    chk("R9 chain ignores fast", len, NORM);
    chk("R5 chain busy level", m_sdo, 0);
    chk("R8 chain enabled", m_oe, 1);
    chk("R5 chain done level", sdo, 1);
    pat = 6'b101101;
    for (int k = 1; k <= N + 6; k++) begin
      read_bit((k <= 6) ? pat[6-k] : 1'b0, b);
      if (k <= N) chk("R6 chain local bits", b, exp_code(18'h1A5C3) >> (N - k) & 1);
      else        chk("R7 chain forwarded bits", b, pat[6-(k-N)]);
    end
    turbo = 1'b0;
    @(negedge clk);
    chk("R9 error flag clear", err_turbo_chain, 0);

    // Random mix
    for (int it = 0; it < 20; it++) begin
      int m;
      logic t;
      m = $urandom_range(0, 2);
      t = (m == 2) ? 1'b0 : 1'($urandom_range(0, 1));
      lvl = N'($urandom);
      wiring_mode = 2'(m); turbo = t; sample_level = lvl;
      sdi = (m == 1) ? 1'b1 : 1'b0;
      run_conv(m == 1, 0, 0, len, f_oe, m_sdo, m_oe);
      chk("R2 random window", len, t ? FAST : NORM);
      chk("R5 random busy level", m_sdo, (m == 2) ? 0 : 1);
      chk("R5 random done level", sdo, (m == 2) ? 1 : 0);
      chk("R8 random enabled", sdo_oe, 1);
      if (m == 2) begin
        pat = 6'($urandom);
        for (int k = 1; k <= N + 6; k++) begin
          read_bit((k <= 6) ? pat[6-k] : 1'b0, b);
          if (k <= N) chk("R4 R6 random chain bits", b, exp_code(lvl) >> (N - k) & 1);
          else        chk("R7 random forwarded", b, pat[6-(k-N)]);
        end
      end else begin
        read_word("R4 R6 random bits", exp_code(lvl), (m == 1) ? 1'b1 : 1'b0);
      end
    end
    turbo = 1'b0;
    finish_up();
  end
endmodule